// File: doc/BRIEF.md
# Synchronous Transfer Offset Limiter

This block gates the data-phase sender of a parallel bus engine. It holds a programmable transfer control register whose low six bits give the maximum synchronous offset. It counts data transfers that have been sent but not yet acknowledged. It raises `may_send_o` only while that count is below the limit that applies in the current phase.

The register can be written through a simple register port. It can also be loaded in parallel by a strobe that fires when a select or reselect operation fetches its settings from a table. The phase input tells the block whether a data phase is active. The `dt_i` input selects between single-transition (ST) and double-transition (DT) data phases.

In non-data phases, and whenever the offset is 0, the block falls back to asynchronous operation, with one transfer outstanding at most. An offset that is illegal for the current data phase raises a configuration error and blocks sending. An acknowledgement that arrives with nothing outstanding sets a sticky underflow flag.

Top module: `sync_offset_limiter`

## Requirements
- R1: After reset the register reads 0x00, the outstanding count is 0, `may_send_o` is 1, and `cfg_err_o` and `underflow_o` are 0.
- R2: A register write stores bits 5:0 of `reg_wdata_i` at the next clock edge. Bits 7:6 of `reg_rdata_o` always read 0, whatever value was written.
- R3: `load_i` stores bits 5:0 of `load_data_i` at the next edge. When `load_i` and `reg_wr_i` are both high in the same cycle, the load value wins.
- R4: Phase codes 0 (data out) and 1 (data in) are data phases. In any other phase, or in a data phase with offset 0, `may_send_o` is 1 only while the outstanding count is 0.
- R5: In an ST data phase (`dt_i`=0) with offset N, where 1 ≤ N ≤ 31, `may_send_o` is 1 exactly while the count is below N.
- R6: In a DT data phase (`dt_i`=1) with offset N, where 2 ≤ N ≤ 62, `may_send_o` is 1 exactly while the count is below N.
- R7: `cfg_err_o` is 1 in a data phase when the offset is above 31 in ST, or is 1 or above 62 in DT. While it is 1, `may_send_o` is 0. `cfg_err_o` follows `phase_i` and `dt_i` in the same cycle.
- R8: A `sent_i` pulse adds one to the count and an `ack_i` pulse removes one. Both in the same cycle leave the count unchanged. The new count shows on `may_send_o` in the cycle after the edge.
- R9: In a cycle where `phase_i` differs from its value at the previous edge, the count becomes 0 at the next edge, and `sent_i`/`ack_i` in that cycle are discarded.
- R10: `ack_i` without `sent_i` while the count is 0 sets `underflow_o` at the next edge. The flag stays set until reset, and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (bits 7:6 zero) |
| load_i | input | 1 | Parallel load strobe from select/reselect |
| load_data_i | input | 8 | Parallel load value |
| phase_i | input | 3 | Bus phase code (0 data out, 1 data in) |
| dt_i | input | 1 | 1 selects double-transition data phases |
| sent_i | input | 1 | One data transfer issued |
| ack_i | input | 1 | One data transfer acknowledged |
| may_send_o | output | 1 | Sender may issue another transfer |
| cfg_err_o | output | 1 | Offset illegal for the current data phase |
| underflow_o | output | 1 | Sticky: acknowledgement with nothing outstanding |

## Verification
Register contents, the outstanding count and the underflow flag change at the clock edge after their stimulus. `cfg_err_o`, and the limit part of `may_send_o`, follow `phase_i` and `dt_i` in the same cycle.

The bench drives each cycle's inputs on the falling edge and lets one rising edge pass. It updates its reference model at that edge and compares every output on the next falling edge, while the same inputs are still applied. The comparison therefore covers both the registered results that are due one cycle later and the combinational results that are due at once.

// File: rtl/slo_pkg.sv
package slo_pkg;
  localparam int unsigned PH_W = 3;
  localparam logic [PH_W-1:0] PH_DOUT = 3'd0;
  localparam logic [PH_W-1:0] PH_DIN  = 3'd1;

  typedef enum logic [1:0] {
    XM_ASYNC = 2'd0,
    XM_ST    = 2'd1,
    XM_DT    = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/slo_xfer_reg.sv
module slo_xfer_reg #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned OFF_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ldata_i,
  output logic [OFF_W-1:0] off_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned RSV_W = REG_W - OFF_W;

  logic [OFF_W-1:0] off_q;

  // load strobe takes priority over register port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    off_q <= '0;
    else if (ld_i)  off_q <= ldata_i[OFF_W-1:0];
    else if (wr_i)  off_q <= wdata_i[OFF_W-1:0];
  end

  assign off_o   = off_q;
  assign rdata_o = {{RSV_W{1'b0}}, off_q};

  p_wr_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !ld_i |=> off_q == $past(wdata_i[OFF_W-1:0]));
  p_ld_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> off_q == $past(ldata_i[OFF_W-1:0]));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i && !wr_i |=> $stable(off_q));
endmodule

// File: rtl/slo_mode_dec.sv
module slo_mode_dec
  import slo_pkg::*;
#(
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned ST_MAX = 31,
  parameter int unsigned DT_MAX = 62
) (
  input  logic [PH_W-1:0]  phase_i,
  input  logic             dt_i,
  input  logic [OFF_W-1:0] off_i,
  output xfer_mode_e       mode_o,
  output logic [OFF_W-1:0] limit_o,
  output logic             cfg_err_o
);
  localparam logic [OFF_W-1:0] ST_LIM = OFF_W'(ST_MAX);
  localparam logic [OFF_W-1:0] DT_LIM = OFF_W'(DT_MAX);
  localparam logic [OFF_W-1:0] ONE    = OFF_W'(1);

  logic data_ph;
  assign data_ph = (phase_i == PH_DOUT) || (phase_i == PH_DIN);

  always_comb begin
    mode_o    = XM_ASYNC;
    limit_o   = ONE;
    cfg_err_o = 1'b0;
    if (data_ph && off_i != '0) begin
      limit_o = off_i;
      if (dt_i) begin
        mode_o    = XM_DT;
        cfg_err_o = (off_i == ONE) || (off_i > DT_LIM);
      end else begin
        mode_o    = XM_ST;
        cfg_err_o = off_i > ST_LIM;
      end
    end
  end
endmodule

// File: rtl/slo_out_cnt.sv
module slo_out_cnt
  import slo_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             sent_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  phase_q;
  logic             uf_q;
  logic             ph_chg;
  logic             inc, dec;

  assign ph_chg = phase_i != phase_q;
  assign inc    = sent_i && !ack_i;
  assign dec    = ack_i && !sent_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_DOUT;
      uf_q    <= 1'b0;
    end else begin
      phase_q <= phase_i;
      if (ph_chg) begin
        cnt_q <= '0;
      end else if (inc) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end else if (dec) begin
        if (cnt_q == '0) uf_q  <= 1'b1;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign underflow_o = uf_q;

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_chg |=> cnt_q == '0);
  p_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_chg && inc && cnt_q != '1 |=> cnt_q == $past(cnt_q) + 1'b1);
  p_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_chg && sent_i && ack_i |=> $stable(cnt_q));
  p_uf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_chg && dec && cnt_q == '0 |=> uf_q && cnt_q == '0);
  p_uf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |=> uf_q);
endmodule

// File: rtl/sync_offset_limiter.sv
module sync_offset_limiter
  import slo_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned ST_MAX = 31,
  parameter int unsigned DT_MAX = 62
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_data_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             dt_i,
  input  logic             sent_i,
  input  logic             ack_i,
  output logic             may_send_o,
  output logic             cfg_err_o,
  output logic             underflow_o
);
  localparam int unsigned CNT_W = OFF_W + 1;

  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  xfer_mode_e       mode;

  slo_xfer_reg #(.REG_W(REG_W), .OFF_W(OFF_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .ld_i    (load_i),
    .ldata_i (load_data_i),
    .off_o   (off),
    .rdata_o (reg_rdata_o)
  );

  slo_mode_dec #(.OFF_W(OFF_W), .ST_MAX(ST_MAX), .DT_MAX(DT_MAX)) u_dec (
    .phase_i   (phase_i),
    .dt_i      (dt_i),
    .off_i     (off),
    .mode_o    (mode),
    .limit_o   (limit),
    .cfg_err_o (cfg_err_o)
  );

  slo_out_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase_i),
    .sent_i      (sent_i),
    .ack_i       (ack_i),
    .cnt_o       (cnt),
    .underflow_o (underflow_o)
  );

  assign may_send_o = !cfg_err_o && (cnt < {1'b0, limit});

  p_err_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !may_send_o);
  p_async_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == XM_ASYNC && cnt != '0 |-> !may_send_o);
  p_sync_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode != XM_ASYNC && !cfg_err_o && cnt < {1'b0, off} |-> may_send_o);
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:OFF_W] == '0);
endmodule

// File: tb/tb_sync_offset_limiter.sv
module tb_sync_offset_limiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       load_i = 1'b0;
  logic [7:0] load_data_i = '0;
  logic [2:0] phase_i = 3'd0;
  logic       dt_i = 1'b0;
  logic       sent_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       may_send_o, cfg_err_o, underflow_o;

  int checks = 0;
  int errors = 0;

  logic [5:0] off_m = '0;
  int         cnt_m = 0;
  logic [2:0] ph_m = 3'd0;
  logic       uf_m = 1'b0;

  always #4 clk_i = ~clk_i;

  sync_offset_limiter dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .load_i(load_i), .load_data_i(load_data_i),
    .phase_i(phase_i), .dt_i(dt_i), .sent_i(sent_i), .ack_i(ack_i),
    .may_send_o(may_send_o), .cfg_err_o(cfg_err_o), .underflow_o(underflow_o)
  );

  function automatic logic is_data(input logic [2:0] ph);
    return ph == 3'd0 || ph == 3'd1;
  endfunction

  function automatic logic exp_err(input logic [2:0] ph, input logic dt, input logic [5:0] off);
    if (!is_data(ph)) return 1'b0;
    if (dt) return off == 6'd1 || off > 6'd62;
    return off > 6'd31;
  endfunction

  function automatic logic exp_may(input logic [2:0] ph, input logic dt, input logic [5:0] off, input int cnt);
    int lim;
    lim = (!is_data(ph) || off == 0) ? 1 : int'(off);
    return !exp_err(ph, dt, off) && cnt < lim;
  endfunction

  function automatic string mode_tag(input logic [2:0] ph, input logic dt, input logic [5:0] off);
    if (!is_data(ph) || off == 0) return "R4";
    if (exp_err(ph, dt, off)) return "R7";
    return dt ? "R6" : "R5";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 rdata", int'(reg_rdata_o), int'({2'b00, off_m}));
    chk({mode_tag(phase_i, dt_i, off_m), " may_send"}, int'(may_send_o),
        int'(exp_may(phase_i, dt_i, off_m, cnt_m)));
    chk("R7 cfg_err", int'(cfg_err_o), int'(exp_err(phase_i, dt_i, off_m)));
    chk("R10 underflow", int'(underflow_o), int'(uf_m));
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic wr, input logic [7:0] wd, input logic ld,
                      input logic [7:0] ldd, input logic [2:0] ph, input logic dt,
                      input logic s, input logic a);
    reg_wr_i = wr; reg_wdata_i = wd; load_i = ld; load_data_i = ldd;
    phase_i = ph; dt_i = dt; sent_i = s; ack_i = a;
    @(posedge clk_i);
    if (ld) off_m = ldd[5:0];
    else if (wr) off_m = wd[5:0];
    if (ph != ph_m) cnt_m = 0;
    else if (s && !a) begin if (cnt_m < 127) cnt_m++; end
    else if (a && !s) begin
      if (cnt_m == 0) uf_m = 1'b1;
      else cnt_m--;
    end
    ph_m = ph;
    @(negedge clk_i);
    check_all();
  endtask

  task automatic idle(input logic [2:0] ph, input logic dt);
    step(1'b0, 8'h00, 1'b0, 8'h00, ph, dt, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", int'(reg_rdata_o), 0);
    chk("R1 may_send", int'(may_send_o), 1);
    chk("R1 cfg_err", int'(cfg_err_o), 0);
    chk("R1 underflow", int'(underflow_o), 0);

    // R2 reserved bits read zero; ST offset 63 is illegal (R7)
    step(1'b1, 8'hFF, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 rsvd", int'(reg_rdata_o), 8'h3F);
    chk("R7 st63", int'(cfg_err_o), 1);
    chk("R7 block", int'(may_send_o), 0);

    // R3 load beats write
    step(1'b1, 8'h09, 1'b1, 8'hC5, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R3 load", int'(reg_rdata_o), 5);

    // R5 ST offset 5
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0);
    chk("R5 full", int'(may_send_o), 0);
    step(1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b1, 1'b1);
    chk("R8 both", int'(may_send_o), 0);
    step(1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1);
    chk("R8 ack", int'(may_send_o), 1);

    // R9 phase change to data-in discards pulses and clears count
    step(1'b0, 8'h00, 1'b0, 8'h00, 3'd1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b0, 8'h00, 3'd1, 1'b0, 1'b1, 1'b0);
    chk("R9 cleared", int'(may_send_o), 1);
    step(1'b0, 8'h00, 1'b0, 8'h00, 3'd1, 1'b0, 1'b1, 1'b0);
    chk("R9 full", int'(may_send_o), 0);

    // R6/R7 DT legality
    step(1'b1, 8'h01, 1'b0, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R7 dt1", int'(cfg_err_o), 1);
    step(1'b1, 8'h3E, 1'b0, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R6 dt62", int'(cfg_err_o), 0);
    chk("R6 dt62 may", int'(may_send_o), 1);
    step(1'b1, 8'h3F, 1'b0, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R7 dt63", int'(cfg_err_o), 1);
    step(1'b1, 8'h3E, 1'b0, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0);

    // R4 non-data phase runs asynchronous
    idle(3'd3, 1'b1);
    step(1'b0, 8'h00, 1'b0, 8'h00, 3'd3, 1'b1, 1'b1, 1'b0);
    chk("R4 single", int'(may_send_o), 0);
    step(1'b0, 8'h00, 1'b0, 8'h00, 3'd3, 1'b1, 1'b0, 1'b1);
    chk("R4 reopen", int'(may_send_o), 1);
    chk("R10 clean", int'(underflow_o), 0);

    // R10 underflow sticky
    step(1'b0, 8'h00, 1'b0, 8'h00, 3'd3, 1'b1, 1'b0, 1'b1);
    chk("R10 set", int'(underflow_o), 1);
    idle(3'd0, 1'b0);
    idle(3'd0, 1'b0);
    chk("R10 sticky", int'(underflow_o), 1);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic wr, ld, s, a, dt;
      logic [7:0] wd, ldd;
      logic [2:0] ph;
      wr  = ($urandom % 40) == 0;
      ld  = ($urandom % 60) == 0;
      wd  = 8'($urandom);
      ldd = 8'($urandom);
      ph  = (($urandom % 30) == 0) ? 3'($urandom % 4) : phase_i;
      dt  = (($urandom % 50) == 0) ? ~dt_i : dt_i;
      s   = ($urandom % 3) == 0;
      a   = (cnt_m > 0) ? (($urandom % 2) == 0) : (($urandom % 50) == 0);
      step(wr, wd, ld, ldd, ph, dt, s, a);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule